// File: doc/BRIEF.md
# I/O Port Access Intercept Decision Unit

This unit decides whether a guest access to an I/O port must be handed to the hypervisor. A request gives a port number, an access width of 1, 2 or 4 bytes, and flags for direction, string form, repeat prefix and immediate-port form. When the bitmap control is set, the unit reads two bytes of intercept bitmap through a single-byte read port. It then tests the bits that cover every port the access touches. When the bitmap control is clear, a second control chooses between exiting on every access and exiting on none.

The port space is split into two halves, each with its own bitmap base address: a low half for ports 0x0000 to 0x7FFF and a high half for ports 0x8000 to 0xFFFF. Each bitmap holds one bit per port. An access that runs off the end of the port space always exits without any bitmap lookup. An access that crosses from the low half into the high half takes one byte from the end of the low bitmap and one byte from the start of the high one. Each decision ends with a one-cycle `done`, together with `exit_o` and the 32-bit exit qualification.

Top module: `io_intercept`

## Requirements
- R1: With the bitmap control set, an access for which port + length exceeds 0x10000 gives `done` and `exit_o` high in the cycle after the request, and issues no bitmap read.
- R2: For an access that stays inside one half, the first read is at (port[15] ? base_hi : base_lo) + port[14:3] and supplies the low byte. The second read is at that address + 1 and supplies the high byte.
- R3: When (port & 0x7FFF) + length exceeds 0x8000, the low byte is read from base_lo + 0xFFF and the high byte from base_hi + 0.
- R4: With the two bytes joined as {high, low}, the access exits exactly when that value ANDed with ((1 << length) − 1) << port[2:0] is nonzero. A set bit belonging to a port outside the access has no effect.
- R5: With the bitmap control clear and the exit-all control set, every access exits in the cycle after the request, with no bitmap read.
- R6: With both controls clear, `done` rises with `exit_o` low in the cycle after the request, with no bitmap read.
- R7: On an exit, `qual` holds length − 1 in [2:0], the in-direction flag in [3], the string flag in [4], the repeat flag in [5], the immediate-form flag in [6], zero in [15:7] and the port in [31:16]. `qual` is zero whenever `exit_o` is low.
- R8: Reads are issued one at a time. `rd_req` stays high with a stable address until `rd_valid` is seen. `done` rises in the cycle after the second byte is accepted.
- R9: A request that arrives while a lookup is in progress is ignored, and no extra `done` is produced for it.
- R10: After reset, `done`, `exit_o` and `rd_req` are low and `qual` is zero.
- R11: With the bitmap control set, the exit-all control has no effect: an access whose bits are clear does not exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_port | input | 16 | I/O port number |
| req_len | input | 3 | Access width in bytes (1, 2 or 4) |
| req_in | input | 1 | Direction is input |
| req_str | input | 1 | String form |
| req_rep | input | 1 | Repeat prefix present |
| req_imm | input | 1 | Port given as an immediate |
| base_lo | input | ADDR_W | Base of the bitmap for ports 0x0000–0x7FFF |
| base_hi | input | ADDR_W | Base of the bitmap for ports 0x8000–0xFFFF |
| ctl_bitmap | input | 1 | Use the bitmaps to decide |
| ctl_exit_all | input | 1 | Exit on every access when bitmaps are off |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |
| done | output | 1 | Decision ready (one cycle) |
| exit_o | output | 1 | Access must exit |
| qual | output | 32 | Exit qualification |

## Verification
The bench attacks the split at port 0x8000. Here a design that simply adds 1 to the first address would fetch the next byte of the low bitmap and miss intercept bits set for ports 0x8000 and above. It also drives port 0xFFFE with 4 bytes, which a unit without the wrap check would turn into a bitmap lookup, and port 0xFFFF with 1 byte, which must not be treated as a wrap. Accesses of 4 bytes at bit offset 6 show whether the high byte is used at all. Other cases show whether a mark on a port just outside the access leaks in, and whether exit-all wrongly overrides a clear bitmap. Read latencies vary, and a request is injected during a lookup. Together these expose a read port that drops its address early, counts of done that are off, and a lookup that is restarted.

// File: rtl/io_intercept.sv
module io_intercept #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [15:0]       req_port,
  input  logic [2:0]        req_len,
  input  logic              req_in,
  input  logic              req_str,
  input  logic              req_rep,
  input  logic              req_imm,
  input  logic [ADDR_W-1:0] base_lo,
  input  logic [ADDR_W-1:0] base_hi,
  input  logic              ctl_bitmap,
  input  logic              ctl_exit_all,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              exit_o,
  output logic [31:0]       qual
);

  localparam int OFF_W = 12;
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;
  st_t st;

  logic [15:0]       p_port;
  logic [2:0]        p_len;
  logic [3:0]        p_flags;
  logic [ADDR_W-1:0] a_lo, a_hi;
  logic [7:0]        lo_byte;

  function automatic logic [31:0] mk_qual(input logic [15:0] pt, input logic [2:0] ln,
                                          input logic [3:0] fl);
    logic [2:0] lm1;
    lm1 = ln - 3'd1;
    return {pt, 9'd0, fl[0], fl[1], fl[2], fl[3], lm1};
  endfunction

  wire        accept  = (st == S_IDLE) && req_valid;
  wire [16:0] end_all = {1'b0, req_port} + {14'd0, req_len};
  wire        wraps   = end_all > 17'h10000;
  wire [15:0] end_hlf = {1'b0, req_port[14:0]} + {13'd0, req_len};
  wire        strad   = end_hlf > 16'h8000;
  wire [3:0]  flg_now = {req_in, req_str, req_rep, req_imm};

  wire [ADDR_W-1:0] off_now = ADDR_W'(req_port[14:3]);
  wire [ADDR_W-1:0] sel_bs  = req_port[15] ? base_hi : base_lo;
  wire [ADDR_W-1:0] nlo     = strad ? base_lo + ADDR_W'(LAST_OFF) : sel_bs + off_now;
  wire [ADDR_W-1:0] nhi     = strad ? base_hi : sel_bs + off_now + ADDR_W'(1);

  wire [15:0] pmask  = ((16'd1 << p_len) - 16'd1) << p_port[2:0];
  wire        hit    = |({rd_data, lo_byte} & pmask);

  assign rd_req  = (st == S_LO) || (st == S_HI);
  assign rd_addr = (st == S_HI) ? a_hi : a_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      p_port  <= '0;
      p_len   <= '0;
      p_flags <= '0;
      a_lo    <= '0;
      a_hi    <= '0;
      lo_byte <= '0;
      done    <= 1'b0;
      exit_o  <= 1'b0;
      qual    <= '0;
    end else begin
      done   <= 1'b0;
      exit_o <= 1'b0;
      qual   <= '0;
      case (st)
        S_IDLE: if (accept) begin
          if (ctl_bitmap && !wraps) begin
            st      <= S_LO;
            p_port  <= req_port;
            p_len   <= req_len;
            p_flags <= flg_now;
            a_lo    <= nlo;
            a_hi    <= nhi;
          end else begin
            done <= 1'b1;
            if (ctl_bitmap || ctl_exit_all) begin
              exit_o <= 1'b1;
              qual   <= mk_qual(req_port, req_len, flg_now);
            end
          end
        end
        S_LO: if (rd_valid) begin
          lo_byte <= rd_data;
          st      <= S_HI;
        end
        S_HI: if (rd_valid) begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (hit) begin
            exit_o <= 1'b1;
            qual   <= mk_qual(p_port, p_len, p_flags);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_wrap_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctl_bitmap && wraps) |=> (done && exit_o && !rd_req));

  p_all_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ctl_bitmap && ctl_exit_all) |=> (done && exit_o && !rd_req));

  p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ctl_bitmap && !ctl_exit_all) |=> (done && !exit_o));

  p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  p_exit_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> (done && qual[15:7] == 9'd0));

  p_qual_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !exit_o |-> (qual == 32'd0));

endmodule

// File: tb/io_intercept_test.sv
module io_intercept_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] BLO = 32'h1000;
  localparam logic [AW-1:0] BHI = 32'h3000;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_in = 0, req_str = 0, req_rep = 0, req_imm = 0;
  logic [15:0] req_port = 0;
  logic [2:0]  req_len = 1;
  logic ctl_bitmap = 0, ctl_exit_all = 0;
  logic rd_req, rd_valid = 0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 0;
  logic done, exit_o;
  logic [31:0] qual;

  io_intercept #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_len(req_len), .req_in(req_in), .req_str(req_str), .req_rep(req_rep),
    .req_imm(req_imm), .base_lo(BLO), .base_hi(BHI), .ctl_bitmap(ctl_bitmap),
    .ctl_exit_all(ctl_exit_all), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .exit_o(exit_o), .qual(qual));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] mem [0:16383];
  int lat = 0, wcnt = 0, rd_cnt = 0;
  logic [AW-1:0] got0, got1;

  always @(negedge clk) begin
    if (rd_req) begin
      if (wcnt >= lat) begin
        rd_valid = 1;
        rd_data  = mem[rd_addr[13:0]];
        if (rd_cnt == 0) got0 = rd_addr; else got1 = rd_addr;
        rd_cnt++;
        wcnt = 0;
      end else begin
        rd_valid = 0;
        wcnt++;
      end
    end else begin
      rd_valid = 0;
      wcnt = 0;
    end
  end

  typedef struct packed {
    logic [15:0] port;
    logic [2:0]  len;
    logic        din, str, rep, imm;
    logic        bm, all;
    logic        mk;
    logic [15:0] mport;
    logic [1:0]  lt;
    logic        exp_exit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'h0060, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0060, 2'd0, 1'b1},
    '{16'h0060, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0061, 2'd1, 1'b0},
    '{16'h0066, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0069, 2'd2, 1'b1},
    '{16'h0066, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h006A, 2'd0, 1'b0},
    '{16'h8010, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h8011, 2'd1, 1'b1},
    '{16'h8010, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0011, 2'd0, 1'b0},
    '{16'h7FFE, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h8001, 2'd2, 1'b1},
    '{16'h7FFE, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h8002, 2'd0, 1'b0},
    '{16'h7FFF, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h7FFF, 2'd1, 1'b1},
    '{16'hFFFE, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 2'd0, 1'b1},
    '{16'hFFFF, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 2'd0, 1'b0},
    '{16'h1234, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 2'd0, 1'b1},
    '{16'h1234, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1234, 2'd0, 1'b0},
    '{16'h0080, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0080, 2'd2, 1'b1}
  };

  function automatic logic [AW-1:0] mark_addr(input logic [15:0] p);
    return (p[15] ? BHI : BLO) + AW'(p[14:3]);
  endfunction

  task automatic do_vec(input vec_t v, input int idx);
    int n;
    bit lookup;
    logic [AW-1:0] e0, e1;
    logic [31:0] eq;
    lookup = v.bm && (32'(v.port) + 32'(v.len) <= 32'h10000);
    if ((32'(v.port[14:0]) + 32'(v.len)) > 32'h8000) begin
      e0 = BLO + 32'hFFF; e1 = BHI;
    end else begin
      e0 = mark_addr(v.port); e1 = e0 + 1;
    end
    eq = v.exp_exit ? {v.port, 9'd0, v.imm, v.rep, v.str, v.din, v.len - 3'd1} : 32'd0;
    if (v.mk) mem[mark_addr(v.mport)[13:0]][v.mport[2:0]] = 1'b1;
    lat = int'(v.lt);
    rd_cnt = 0; got0 = '0; got1 = '0;
    req_port = v.port; req_len = v.len; req_in = v.din; req_str = v.str;
    req_rep = v.rep; req_imm = v.imm; ctl_bitmap = v.bm; ctl_exit_all = v.all;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    $display("vector %0d", idx);
    // R8 / R1 / R5 / R6: latency of done
    chk(n == (lookup ? 1 + 2 * (lat + 1) : 1), "R8 done latency", 32'(n), 32'(lookup ? 1 + 2 * (lat + 1) : 1));
    // R4 / R11 / R1 / R5 / R6: decision
    chk(exit_o == v.exp_exit, "R4 exit decision", 32'(exit_o), 32'(v.exp_exit));
    // R7: qualification
    chk(qual == eq, "R7 qualification", qual, eq);
    // R1 / R5 / R6: number of bitmap reads
    chk(rd_cnt == (lookup ? 2 : 0), "R1 read count", 32'(rd_cnt), lookup ? 32'd2 : 32'd0);
    if (lookup) begin
      chk(got0 == e0, "R2 R3 low byte address", got0, e0);
      chk(got1 == e1, "R2 R3 high byte address", got1, e1);
    end
    if (v.mk) mem[mark_addr(v.mport)[13:0]] = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 0, "R10 done in reset", 32'(done), 0);
    chk(exit_o == 0, "R10 exit in reset", 32'(exit_o), 0);
    chk(rd_req == 0, "R10 rd_req in reset", 32'(rd_req), 0);
    chk(qual == 0, "R10 qual in reset", qual, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) do_vec(VEC[i], i);

    // R9: request during a lookup is ignored
    begin
      int dn;
      bit ex;
      dn = 0; ex = 0;
      lat = 3; rd_cnt = 0;
      req_port = 16'h0040; req_len = 3'd1; ctl_bitmap = 1; ctl_exit_all = 0;
      req_in = 0; req_str = 0; req_rep = 0; req_imm = 0;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      req_port = 16'hFFFE; req_len = 3'd4;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      for (int k = 0; k < 20; k++) begin
        if (done) begin dn++; ex = exit_o; end
        @(negedge clk);
      end
      chk(dn == 1, "R9 single done", 32'(dn), 1);
      chk(ex == 0, "R9 first request decides", 32'(ex), 0);
      chk(rd_cnt == 2, "R9 reads of first request", 32'(rd_cnt), 2);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule